// File: doc/BRIEF.md
# Transfer Descriptor Status Writeback

This block closes out one bus transaction for a host controller. It takes the 32-bit control/status word and the 32-bit token word of the transfer descriptor that was just executed, together with the outcome the serial engine reported. The outcome is made of three handshake indications (ACK, NAK, STALL), four error indications (CRC/timeout, babble, data buffer error, bit-stuff error) and the received byte count. One clock after a request it presents the updated status word for the descriptor fetcher to store back, plus one-cycle strobes for completion, short packet and process error.

The token is checked first. The packet identifier must be one of the three accepted codes, and the maximum-length field must be legal. The status word is then rebuilt. The error flags are replaced by this transaction's outcome. The 2-bit error budget is spent on CRC/timeout and bit-stuff errors. A fatal condition or an exhausted budget retires the descriptor as stalled. A NAK keeps the descriptor live for a later frame. A successful transfer records its length in the minus-one encoding, where code 0x7FF means zero bytes.

Top module: `td_status_wb`

## Requirements
- R1: While `rst_n` is low, and until the first request after reset, `wb_valid`, `irq_done`, `irq_short` and `proc_err` are 0.
- R2: A request on an active descriptor is processed only if the token PID (bits 7:0) is 0x2D (SETUP), 0xE1 (OUT) or 0x69 (IN), and the maximum-length code (bits 31:21) is at most 0x4FF or equals 0x7FF. Otherwise `proc_err` pulses for exactly one cycle, in the cycle after the request, and `wb_valid` stays 0.
- R3: A request whose status word has the active bit (bit 23) clear is ignored. No writeback, completion, short-packet or process-error strobe follows.
- R4: On an ACK with no fatal or transfer error, the written status word has active (bit 23) cleared and flag bits 22:16 cleared. Bits 10:0 hold the received byte count minus one, and a count of 0 is written as 0x7FF. `wb_valid` pulses for one cycle, one clock after the request.
- R5: On such a successful transfer with interrupt-on-completion (bit 24) set, `irq_done` pulses together with `wb_valid`. It never pulses on any other outcome.
- R6: On a successful IN transfer with short-packet detect (bit 29) set, `irq_short` pulses and active is cleared when the received count is below the token's maximum (code+1 bytes, 0x7FF meaning 0). OUT and SETUP transfers never raise it.
- R7: A NAK with no error sets bit 19 and keeps active set. The error count (bits 28:27) and the length (bits 10:0) are unchanged.
- R8: A CRC/timeout (bit 18) or bit-stuff (bit 17) error records its flag. A nonzero error count is decremented, and when it reaches 0, active is cleared and stalled (bit 22) is set. A count of 0 at entry is left at 0 and keeps active set.
- R9: A STALL handshake, babble or data buffer error clears active at once and sets stalled (bit 22), babble (bit 20) or data buffer error (bit 21) respectively. It takes priority over every other outcome and leaves the error count unchanged.
- R10: A request with no handshake and no error indication at all is treated as a timeout under R8.
- R11: Bits 31:29 and 26:24 pass through unchanged, and reserved bit 16 is always written as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request: descriptor words and outcome are valid |
| td_ctl | input | 32 | Descriptor control/status word as fetched |
| td_tok | input | 32 | Descriptor token word |
| rsp_ack | input | 1 | ACK handshake seen |
| rsp_nak | input | 1 | NAK handshake seen |
| rsp_stall | input | 1 | STALL handshake seen |
| err_crc_to | input | 1 | CRC or timeout error |
| err_babble | input | 1 | Babble detected |
| err_dbuf | input | 1 | Data buffer overrun/underrun |
| err_bitstuff | input | 1 | Bit-stuff error |
| rx_bytes | input | 11 | Bytes actually transferred (plain count) |
| wb_valid | output | 1 | Updated status word is valid for writeback |
| wb_ctl | output | 32 | Updated status word |
| irq_done | output | 1 | Completion interrupt strobe |
| irq_short | output | 1 | Short-packet interrupt strobe |
| proc_err | output | 1 | Malformed token strobe |

## Verification
The bench targets the length encoding at both ends. Counts of 0, 1, 64 and 1280 are checked, so an off-by-one or a missing null code shows up as a wrong bits 10:0. The error budget is walked from 3 down to 0 and retried at 0. A design that retires at 1 or wraps 0 to 3 leaves the active or stalled bit wrong. Mixed outcomes (STALL with CRC, babble with ACK) pin the priority order, and codes 0x4FF, 0x500, 0x7FE and 0x7FF probe the token legality edge. Short-packet detection is checked on an OUT transfer and on a full-size IN transfer, where a strobe must not appear.

// File: rtl/tdwb_pkg.sv
package tdwb_pkg;

  localparam int unsigned CTL_W = 32;

  // Status word bit positions (decoded by the descriptor owner)
  localparam int unsigned BIT_SPD    = 29;
  localparam int unsigned ERR_LO     = 27;
  localparam int unsigned BIT_IOC    = 24;
  localparam int unsigned BIT_ACT    = 23;
  localparam int unsigned BIT_STALL  = 22;
  localparam int unsigned BIT_DBUF   = 21;
  localparam int unsigned BIT_BABBLE = 20;
  localparam int unsigned BIT_NAK    = 19;
  localparam int unsigned BIT_CRC    = 18;
  localparam int unsigned BIT_BSTUFF = 17;
  localparam int unsigned BIT_RSVD   = 16;

  // Token field positions
  localparam int unsigned TOK_LEN_LO = 21;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;

  typedef enum logic [1:0] {
    CLS_ACK   = 2'd0,
    CLS_NAK   = 2'd1,
    CLS_XERR  = 2'd2,
    CLS_FATAL = 2'd3
  } tx_class_e;

endpackage

// File: rtl/td_rst_sync.sv
module td_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/td_token_check.sv
module td_token_check
  import tdwb_pkg::*;
#(
  parameter int unsigned    LEN_W = 11,
  parameter logic [LEN_W-1:0] LIMIT = 11'h4FF
) (
  input  logic [CTL_W-1:0] tok,
  output logic             tok_ok,
  output logic             is_in,
  output logic [LEN_W:0]   max_bytes
);

  localparam logic [LEN_W-1:0] NULL_CODE = '1;

  logic [7:0]       pid;
  logic [LEN_W-1:0] len_code;
  logic             pid_ok;
  logic             len_ok;

  always_comb begin
    pid      = tok[7:0];
    len_code = tok[TOK_LEN_LO +: LEN_W];
    unique case (pid)
      PID_SETUP, PID_OUT, PID_IN: pid_ok = 1'b1;
      default:                    pid_ok = 1'b0;
    endcase
    len_ok = (len_code <= LIMIT) || (len_code == NULL_CODE);
    tok_ok = pid_ok && len_ok;
    is_in  = (pid == PID_IN);
    if (len_code == NULL_CODE) begin
      max_bytes = '0;
    end else begin
      max_bytes = {1'b0, len_code} + 1'b1;
    end
  end

endmodule

// File: rtl/td_outcome_class.sv
module td_outcome_class
  import tdwb_pkg::*;
(
  input  logic      rsp_ack,
  input  logic      rsp_nak,
  input  logic      rsp_stall,
  input  logic      err_crc_to,
  input  logic      err_babble,
  input  logic      err_dbuf,
  input  logic      err_bitstuff,
  output tx_class_e cls,
  output logic      no_resp
);

  logic fatal;
  logic xerr;

  always_comb begin
    no_resp = !(rsp_ack || rsp_nak || rsp_stall || err_crc_to ||
                err_babble || err_dbuf || err_bitstuff);
    fatal   = rsp_stall || err_babble || err_dbuf;
    xerr    = err_crc_to || err_bitstuff || no_resp;
    if (fatal) begin
      cls = CLS_FATAL;
    end else if (xerr) begin
      cls = CLS_XERR;
    end else if (rsp_nak) begin
      cls = CLS_NAK;
    end else begin
      cls = CLS_ACK;
    end
  end

endmodule

// File: rtl/td_status_next.sv
module td_status_next
  import tdwb_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned ERR_W = 2
) (
  input  logic [CTL_W-1:0] ctl,
  input  tx_class_e        cls,
  input  logic             no_resp,
  input  logic             rsp_stall,
  input  logic             err_crc_to,
  input  logic             err_babble,
  input  logic             err_dbuf,
  input  logic             err_bitstuff,
  input  logic [LEN_W-1:0] rx_bytes,
  input  logic             is_in,
  input  logic [LEN_W:0]   max_bytes,
  output logic [CTL_W-1:0] nxt,
  output logic             done,
  output logic             short_pkt
);

  localparam int unsigned      ERR_HI    = ERR_LO + ERR_W - 1;
  localparam logic [LEN_W-1:0] NULL_CODE = '1;

  logic [ERR_W-1:0] cnt;
  logic [ERR_W-1:0] cnt_dec;
  logic [LEN_W-1:0] len_enc;

  always_comb begin
    cnt     = ctl[ERR_HI:ERR_LO];
    cnt_dec = cnt - 1'b1;
    len_enc = (rx_bytes == '0) ? NULL_CODE : rx_bytes - 1'b1;

    nxt                     = ctl;
    nxt[BIT_STALL:BIT_RSVD] = '0;
    nxt[BIT_DBUF]           = err_dbuf;
    nxt[BIT_BABBLE]         = err_babble;
    nxt[BIT_CRC]            = err_crc_to || no_resp;
    nxt[BIT_BSTUFF]         = err_bitstuff;
    done                    = 1'b0;
    short_pkt               = 1'b0;

    unique case (cls)
      CLS_FATAL: begin
        nxt[BIT_ACT]   = 1'b0;
        nxt[BIT_STALL] = rsp_stall;
      end
      CLS_XERR: begin
        if (cnt != '0) begin
          nxt[ERR_HI:ERR_LO] = cnt_dec;
          if (cnt_dec == '0) begin
            nxt[BIT_ACT]   = 1'b0;
            nxt[BIT_STALL] = 1'b1;
          end
        end
      end
      CLS_NAK: begin
        nxt[BIT_NAK] = 1'b1;
      end
      default: begin
        nxt[BIT_ACT]     = 1'b0;
        nxt[LEN_W-1:0]   = len_enc;
        done             = ctl[BIT_IOC];
        short_pkt        = is_in && ctl[BIT_SPD] &&
                           ({1'b0, rx_bytes} < max_bytes);
      end
    endcase
  end

endmodule

// File: rtl/td_status_wb.sv
module td_status_wb
  import tdwb_pkg::*;
#(
  parameter int unsigned      LEN_W     = 11,
  parameter int unsigned      ERR_W     = 2,
  parameter logic [LEN_W-1:0] LEN_LIMIT = 11'h4FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      td_ctl,
  input  logic [31:0]      td_tok,
  input  logic             rsp_ack,
  input  logic             rsp_nak,
  input  logic             rsp_stall,
  input  logic             err_crc_to,
  input  logic             err_babble,
  input  logic             err_dbuf,
  input  logic             err_bitstuff,
  input  logic [LEN_W-1:0] rx_bytes,
  output logic             wb_valid,
  output logic [31:0]      wb_ctl,
  output logic             irq_done,
  output logic             irq_short,
  output logic             proc_err
);

  logic             rst_q;
  logic             tok_ok;
  logic             is_in;
  logic [LEN_W:0]   max_bytes;
  tx_class_e        cls;
  logic             no_resp;
  logic [CTL_W-1:0] ctl_nxt;
  logic             done_c;
  logic             short_c;

  logic             accept;
  logic             wb_d;
  logic             perr_d;
  logic             done_d;
  logic             short_d;

  logic             wb_q;
  logic             perr_q;
  logic             done_q;
  logic             short_q;
  logic [CTL_W-1:0] ctl_q;

  td_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  td_token_check #(.LEN_W(LEN_W), .LIMIT(LEN_LIMIT)) u_tok (
    .tok       (td_tok),
    .tok_ok    (tok_ok),
    .is_in     (is_in),
    .max_bytes (max_bytes)
  );

  td_outcome_class u_cls (
    .rsp_ack      (rsp_ack),
    .rsp_nak      (rsp_nak),
    .rsp_stall    (rsp_stall),
    .err_crc_to   (err_crc_to),
    .err_babble   (err_babble),
    .err_dbuf     (err_dbuf),
    .err_bitstuff (err_bitstuff),
    .cls          (cls),
    .no_resp      (no_resp)
  );

  td_status_next #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_nxt (
    .ctl          (td_ctl),
    .cls          (cls),
    .no_resp      (no_resp),
    .rsp_stall    (rsp_stall),
    .err_crc_to   (err_crc_to),
    .err_babble   (err_babble),
    .err_dbuf     (err_dbuf),
    .err_bitstuff (err_bitstuff),
    .rx_bytes     (rx_bytes),
    .is_in        (is_in),
    .max_bytes    (max_bytes),
    .nxt          (ctl_nxt),
    .done         (done_c),
    .short_pkt    (short_c)
  );

  // Next-state decision
  always_comb begin
    accept  = req_valid && td_ctl[BIT_ACT];
    wb_d    = accept && tok_ok;
    perr_d  = accept && !tok_ok;
    done_d  = wb_d && done_c;
    short_d = wb_d && short_c;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      wb_q    <= 1'b0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      wb_q    <= wb_d;
      perr_q  <= perr_d;
      done_q  <= done_d;
      short_q <= short_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctl_q <= '0;
    end else if (wb_d) begin
      ctl_q <= ctl_nxt;
    end
  end

  assign wb_valid  = wb_q;
  assign wb_ctl    = ctl_q;
  assign irq_done  = done_q;
  assign irq_short = short_q;
  assign proc_err  = perr_q;

  AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_q)
    (wb_q || perr_q) |-> $past(req_valid)); // R4
  AST_WB_PERR_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    !(wb_q && perr_q)); // R2
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !td_ctl[BIT_ACT]) |=> (!wb_q && !perr_q && !done_q && !short_q)); // R3
  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> (wb_q && !ctl_q[BIT_ACT] && !ctl_q[BIT_NAK])); // R5
  AST_SHORT_RETIRES: assert property (@(posedge clk) disable iff (!rst_q)
    short_q |-> (wb_q && !ctl_q[BIT_ACT])); // R6
  AST_NAK_STAYS_LIVE: assert property (@(posedge clk) disable iff (!rst_q)
    (wb_q && ctl_q[BIT_NAK]) |-> ctl_q[BIT_ACT]); // R7
  AST_STALL_RETIRES: assert property (@(posedge clk) disable iff (!rst_q)
    (wb_q && ctl_q[BIT_STALL]) |-> !ctl_q[BIT_ACT]); // R9
  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_q)
    wb_q |-> !ctl_q[BIT_RSVD]); // R11
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_q)
    !wb_q |-> $stable(ctl_q)); // R4

endmodule

// File: tb/test_td_status_wb.sv
module test_td_status_wb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] td_ctl;
  logic [31:0] td_tok;
  logic        rsp_ack, rsp_nak, rsp_stall;
  logic        err_crc_to, err_babble, err_dbuf, err_bitstuff;
  logic [10:0] rx_bytes;
  logic        wb_valid;
  logic [31:0] wb_ctl;
  logic        irq_done, irq_short, proc_err;

  int vectors = 0;
  int misses  = 0;

  localparam logic [6:0] O_ACK = 7'b1000000;
  localparam logic [6:0] O_NAK = 7'b0100000;
  localparam logic [6:0] O_STL = 7'b0010000;
  localparam logic [6:0] O_CRC = 7'b0001000;
  localparam logic [6:0] O_BAB = 7'b0000100;
  localparam logic [6:0] O_DBF = 7'b0000010;
  localparam logic [6:0] O_BST = 7'b0000001;

  localparam logic [31:0] F_STALL = 32'h0040_0000;
  localparam logic [31:0] F_DBUF  = 32'h0020_0000;
  localparam logic [31:0] F_BAB   = 32'h0010_0000;
  localparam logic [31:0] F_NAK   = 32'h0008_0000;
  localparam logic [31:0] F_CRC   = 32'h0004_0000;
  localparam logic [31:0] F_BS    = 32'h0002_0000;
  localparam logic [31:0] F_RSV   = 32'h0001_0000;
  localparam logic [31:0] PASS    = 32'hC600_0000;

  localparam logic [7:0] P_SETUP = 8'h2D;
  localparam logic [7:0] P_OUT   = 8'hE1;
  localparam logic [7:0] P_IN    = 8'h69;

  td_status_wb i_td_status_wb (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .td_ctl       (td_ctl),
    .td_tok       (td_tok),
    .rsp_ack      (rsp_ack),
    .rsp_nak      (rsp_nak),
    .rsp_stall    (rsp_stall),
    .err_crc_to   (err_crc_to),
    .err_babble   (err_babble),
    .err_dbuf     (err_dbuf),
    .err_bitstuff (err_bitstuff),
    .rx_bytes     (rx_bytes),
    .wb_valid     (wb_valid),
    .wb_ctl       (wb_ctl),
    .irq_done     (irq_done),
    .irq_short    (irq_short),
    .proc_err     (proc_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic spd, input logic [1:0] cnt,
                                     input logic ioc, input logic act,
                                     input logic [10:0] len);
    return {2'b00, spd, cnt, 2'b00, ioc, act, 12'h000, len};
  endfunction

  function automatic logic [31:0] tk(input logic [10:0] len, input logic [7:0] pid);
    return {len, 6'b000000, 7'h05, pid};
  endfunction

  task automatic drive(input logic rq, input logic [31:0] c, input logic [31:0] t,
                       input logic [6:0] oc, input logic [10:0] rx);
    req_valid = rq;
    td_ctl    = c;
    td_tok    = t;
    {rsp_ack, rsp_nak, rsp_stall, err_crc_to, err_babble, err_dbuf, err_bitstuff} = oc;
    rx_bytes  = rx;
  endtask

  task automatic apply(input string tag, input logic [31:0] c, input logic [31:0] t,
                       input logic [6:0] oc, input logic [10:0] rx,
                       input logic e_wb, input logic [31:0] e_ctl,
                       input logic e_done, input logic e_short, input logic e_perr);
    @(negedge clk);
    drive(1'b1, c, t, oc, rx);
    @(posedge clk);
    #1;
    vectors++;
    if (wb_valid !== e_wb || (e_wb && wb_ctl !== e_ctl) || irq_done !== e_done ||
        irq_short !== e_short || proc_err !== e_perr) begin
      misses++;
      $display("FAIL %s: actual wb=%b ctl=%h done=%b short=%b perr=%b expected wb=%b ctl=%h done=%b short=%b perr=%b",
               tag, wb_valid, wb_ctl, irq_done, irq_short, proc_err,
               e_wb, e_ctl, e_done, e_short, e_perr);
    end
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 7'h00, 11'h000);
    @(posedge clk);
    #1;
    vectors++;
    if (wb_valid !== 1'b0 || irq_done !== 1'b0 || irq_short !== 1'b0 || proc_err !== 1'b0) begin
      misses++;
      $display("FAIL %s (one-cycle pulse R4): actual wb=%b done=%b short=%b perr=%b expected all 0",
               tag, wb_valid, irq_done, irq_short, proc_err);
    end
  endtask

  task automatic t_reset;
    drive(1'b0, 32'h0, 32'h0, 7'h00, 11'h000);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (wb_valid !== 1'b0 || irq_done !== 1'b0 || irq_short !== 1'b0 || proc_err !== 1'b0) begin
      misses++;
      $display("FAIL R1 reset: actual wb=%b done=%b short=%b perr=%b expected 0000",
               wb_valid, irq_done, irq_short, proc_err);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (wb_valid !== 1'b0 || proc_err !== 1'b0) begin
      misses++;
      $display("FAIL R1 after release: actual wb=%b perr=%b expected 00", wb_valid, proc_err);
    end
  endtask

  task automatic t_ack;
    apply("R4 ack 64 bytes, old flags cleared",
          mk(0, 2'd3, 0, 1, 11'h7FF) | F_NAK | F_RSV | F_CRC, tk(11'h03F, P_OUT), O_ACK, 11'd64,
          1, mk(0, 2'd3, 0, 0, 11'h03F), 0, 0, 0);
    apply("R4 ack zero bytes -> 0x7FF",
          mk(0, 2'd3, 0, 1, 11'h123), tk(11'h03F, P_OUT), O_ACK, 11'd0,
          1, mk(0, 2'd3, 0, 0, 11'h7FF), 0, 0, 0);
    apply("R4 ack one byte -> 0x000",
          mk(0, 2'd3, 0, 1, 11'h7FF), tk(11'h03F, P_OUT), O_ACK, 11'd1,
          1, mk(0, 2'd3, 0, 0, 11'h000), 0, 0, 0);
    apply("R11 passthrough bits, reserved cleared",
          mk(0, 2'd1, 0, 1, 11'h000) | PASS | F_RSV, tk(11'h007, P_OUT), O_ACK, 11'd5,
          1, mk(0, 2'd1, 0, 0, 11'h004) | PASS, 0, 0, 0);
  endtask

  task automatic t_ioc;
    apply("R5 ioc on success",
          mk(0, 2'd3, 1, 1, 11'h7FF), tk(11'h007, P_OUT), O_ACK, 11'd8,
          1, mk(0, 2'd3, 1, 0, 11'h007), 1, 0, 0);
    apply("R5 no ioc strobe on NAK",
          mk(0, 2'd3, 1, 1, 11'h7FF), tk(11'h007, P_OUT), O_NAK, 11'd0,
          1, mk(0, 2'd3, 1, 1, 11'h7FF) | F_NAK, 0, 0, 0);
  endtask

  task automatic t_short;
    apply("R6 IN short packet",
          mk(1, 2'd3, 0, 1, 11'h7FF), tk(11'h03F, P_IN), O_ACK, 11'd10,
          1, mk(1, 2'd3, 0, 0, 11'h009), 0, 1, 0);
    apply("R6 IN full packet no short",
          mk(1, 2'd3, 0, 1, 11'h7FF), tk(11'h03F, P_IN), O_ACK, 11'd64,
          1, mk(1, 2'd3, 0, 0, 11'h03F), 0, 0, 0);
    apply("R6 OUT never short",
          mk(1, 2'd3, 0, 1, 11'h7FF), tk(11'h03F, P_OUT), O_ACK, 11'd10,
          1, mk(1, 2'd3, 0, 0, 11'h009), 0, 0, 0);
    apply("R6 IN detect disabled",
          mk(0, 2'd3, 0, 1, 11'h7FF), tk(11'h03F, P_IN), O_ACK, 11'd10,
          1, mk(0, 2'd3, 0, 0, 11'h009), 0, 0, 0);
    apply("R6 R5 short and ioc together",
          mk(1, 2'd3, 1, 1, 11'h7FF), tk(11'h007, P_IN), O_ACK, 11'd0,
          1, mk(1, 2'd3, 1, 0, 11'h7FF), 1, 1, 0);
    apply("R6 IN null-length token not short",
          mk(1, 2'd3, 0, 1, 11'h000), tk(11'h7FF, P_IN), O_ACK, 11'd0,
          1, mk(1, 2'd3, 0, 0, 11'h7FF), 0, 0, 0);
  endtask

  task automatic t_token;
    apply("R2 max legal 0x4FF, 1280 bytes",
          mk(1, 2'd3, 0, 1, 11'h7FF), tk(11'h4FF, P_IN), O_ACK, 11'd1280,
          1, mk(1, 2'd3, 0, 0, 11'h4FF), 0, 0, 0);
    apply("R2 SETUP null length accepted",
          mk(0, 2'd3, 0, 1, 11'h055), tk(11'h7FF, P_SETUP), O_ACK, 11'd0,
          1, mk(0, 2'd3, 0, 0, 11'h7FF), 0, 0, 0);
    apply("R2 length 0x500 rejected",
          mk(0, 2'd3, 1, 1, 11'h7FF), tk(11'h500, P_OUT), O_ACK, 11'd8,
          0, 32'h0, 0, 0, 1);
    apply("R2 length 0x7FE rejected",
          mk(0, 2'd3, 0, 1, 11'h7FF), tk(11'h7FE, P_IN), O_ACK, 11'd8,
          0, 32'h0, 0, 0, 1);
    apply("R2 unknown PID 0x96",
          mk(0, 2'd3, 0, 1, 11'h7FF), tk(11'h007, 8'h96), O_ACK, 11'd8,
          0, 32'h0, 0, 0, 1);
    apply("R2 unknown PID 0x55",
          mk(0, 2'd3, 0, 1, 11'h7FF), tk(11'h007, 8'h55), O_NAK, 11'd0,
          0, 32'h0, 0, 0, 1);
  endtask

  task automatic t_inactive;
    apply("R3 inactive descriptor ignored",
          mk(1, 2'd3, 1, 0, 11'h055), tk(11'h03F, P_IN), O_ACK, 11'd3,
          0, 32'h0, 0, 0, 0);
    apply("R3 inactive with bad token ignored",
          mk(0, 2'd3, 0, 0, 11'h055), tk(11'h500, 8'h00), O_ACK, 11'd3,
          0, 32'h0, 0, 0, 0);
  endtask

  task automatic t_nak;
    apply("R7 NAK keeps active, count, length",
          mk(0, 2'd2, 1, 1, 11'h123), tk(11'h03F, P_IN), O_NAK, 11'd7,
          1, mk(0, 2'd2, 1, 1, 11'h123) | F_NAK, 0, 0, 0);
  endtask

  task automatic t_retry;
    apply("R8 crc 3->2 stays active",
          mk(0, 2'd3, 0, 1, 11'h7FF), tk(11'h03F, P_IN), O_CRC, 11'd0,
          1, mk(0, 2'd2, 0, 1, 11'h7FF) | F_CRC, 0, 0, 0);
    apply("R8 crc 2->1 stays active",
          mk(0, 2'd2, 0, 1, 11'h7FF) | F_CRC, tk(11'h03F, P_IN), O_CRC, 11'd0,
          1, mk(0, 2'd1, 0, 1, 11'h7FF) | F_CRC, 0, 0, 0);
    apply("R8 bitstuff 1->0 retires stalled",
          mk(0, 2'd1, 1, 1, 11'h7FF), tk(11'h03F, P_IN), O_BST, 11'd0,
          1, mk(0, 2'd0, 1, 0, 11'h7FF) | F_BS | F_STALL, 0, 0, 0);
    apply("R8 count 0 unlimited retries",
          mk(0, 2'd0, 0, 1, 11'h7FF), tk(11'h03F, P_OUT), O_CRC, 11'd0,
          1, mk(0, 2'd0, 0, 1, 11'h7FF) | F_CRC, 0, 0, 0);
    apply("R8 crc wins over ack",
          mk(0, 2'd3, 1, 1, 11'h7FF), tk(11'h03F, P_OUT), O_CRC | O_ACK, 11'd8,
          1, mk(0, 2'd2, 1, 1, 11'h7FF) | F_CRC, 0, 0, 0);
    apply("R10 no response counted as timeout",
          mk(0, 2'd2, 0, 1, 11'h7FF), tk(11'h03F, P_IN), 7'h00, 11'd0,
          1, mk(0, 2'd1, 0, 1, 11'h7FF) | F_CRC, 0, 0, 0);
  endtask

  task automatic t_fatal;
    apply("R9 stall with crc, count kept",
          mk(0, 2'd3, 0, 1, 11'h010), tk(11'h03F, P_OUT), O_STL | O_CRC, 11'd0,
          1, mk(0, 2'd3, 0, 0, 11'h010) | F_STALL | F_CRC, 0, 0, 0);
    apply("R9 babble beats ack, no ioc",
          mk(0, 2'd2, 1, 1, 11'h010), tk(11'h03F, P_IN), O_BAB | O_ACK, 11'd5,
          1, mk(0, 2'd2, 1, 0, 11'h010) | F_BAB, 0, 0, 0);
    apply("R9 data buffer error with count 0",
          mk(0, 2'd0, 0, 1, 11'h010), tk(11'h03F, P_OUT), O_DBF, 11'd0,
          1, mk(0, 2'd0, 0, 0, 11'h010) | F_DBUF, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog R1-scope run hung: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_ack();
    t_ioc();
    t_short();
    t_token();
    t_inactive();
    t_nak();
    t_retry();
    t_fatal();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule